// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full `2*WIDTH`-bit product. It recodes the multiplier in overlapping three-bit windows, so each cycle retires two multiplier bits. Each window selects one multiple of the multiplicand: zero, plus or minus one times, or plus or minus two times. After `WIDTH/2` additions into a sign-extended accumulator, the product is ready.

A caller raises `start_i` with both operands while `busy_o` is low. The operands are captured on that edge and `busy_o` rises. `WIDTH/2` edges later, `done_o` pulses for one cycle. In that cycle `busy_o` is low and `product_o` holds the new result. A new start can be accepted in the same cycle as `done_o`. `WIDTH` must be even.

Top module: `radix4_booth_mul`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `busy_o`, `done_o` and `product_o` are all zero.
- R2: Each step reads multiplier bits (2k+1, 2k, 2k-1), with bit -1 taken as 0. It adds the multiplicand times the digit the window encodes: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. The result is weighted by 4^k.
- R3: In the `done_o` cycle, `product_o` equals the exact signed product of the captured multiplicand and multiplier, all `2*WIDTH` bits.
- R4: `done_o` is high for exactly one cycle. It rises `WIDTH/2` clock edges after the edge that accepted the start.
- R5: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`, and it is low in the `done_o` cycle.
- R6: `start_i` and the operand inputs are ignored while `busy_o` is high. The result in flight is not altered.
- R7: A start presented in the `done_o` cycle is accepted, so multiplications can run back to back every `WIDTH/2 + 1` cycles.
- R8: Outside the `done_o` cycle, `product_o` holds its last value.
- R9: Extreme operands are exact, including the most negative value times itself and the most negative value times the most positive.
- R10: Negative multiples are sign-extended across the full product width, so a negative multiplicand with a positive multiplier gives a correct negative product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiplication; taken only when not busy |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle result strobe |
| product_o | output | 2*WIDTH | Signed product, held between strobes |

## Verification
The result strobe of one multiplication and the acceptance of the next start can occur in the same cycle. The bench provokes this on every run of its operand sweep: each new start is driven in the cycle where the previous `done_o` is high. The bench then judges it by three checks. The previous product must be correct in that cycle. `busy_o` must be high in the following cycle. The new product must arrive exactly `WIDTH/2` edges later. A second overlap, a start raised while busy, is checked at the ports: the in-flight product must still match the operands that were captured first.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_N1   = 3'd3,
    DIG_N2   = 3'd4
  } booth_dig_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic [2:0] trip_i,
  output booth_dig_e dig_o
);
  always_comb begin
    unique case (trip_i)
      3'b001, 3'b010: dig_o = DIG_P1;
      3'b011:         dig_o = DIG_P2;
      3'b100:         dig_o = DIG_N2;
      3'b101, 3'b110: dig_o = DIG_N1;
      default:        dig_o = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_multiple_sel.sv
module booth_multiple_sel
  import booth_mul_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  booth_dig_e        dig_i,
  input  logic [PW-1:0]     mcand_i,
  output logic [PW-1:0]     addend_o,
  output logic              cin_o
);
  logic [PW-1:0] mag;
  logic          neg;

  always_comb begin
    unique case (dig_i)
      DIG_P1, DIG_N1: mag = mcand_i;
      DIG_P2, DIG_N2: mag = {mcand_i[PW-2:0], 1'b0};
      default:        mag = '0;
    endcase
    neg      = (dig_i == DIG_N1) || (dig_i == DIG_N2);
    // subtract by adding the two's complement: invert here, +1 via carry-in
    addend_o = neg ? ~mag : mag;
    cin_o    = neg;
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int unsigned STEPS = 4,
  localparam int unsigned CW   = $clog2(STEPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign accept_o = start_i && !busy_q;
  assign last_o   = busy_q && (cnt_q == CW'(STEPS - 1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/radix4_booth_mul.sv
module radix4_booth_mul
  import booth_mul_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int unsigned PW    = 2 * WIDTH;
  localparam int unsigned STEPS = WIDTH / 2;

  logic [PW-1:0]  mcand_sh;
  logic [WIDTH:0] mplier_sh;
  logic [PW-1:0]  acc_q;
  logic [PW-1:0]  prod_q;
  logic [PW-1:0]  addend;
  logic [PW-1:0]  acc_sum;
  logic           cin;
  logic           accept;
  logic           busy;
  logic           last;
  booth_dig_e     dig;

  booth_seq_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .busy_o  (busy),
    .last_o  (last),
    .done_o  (done_o)
  );

  booth_recoder i_rec (
    .trip_i(mplier_sh[2:0]),
    .dig_o (dig)
  );

  booth_multiple_sel #(.PW(PW)) i_sel (
    .dig_i   (dig),
    .mcand_i (mcand_sh),
    .addend_o(addend),
    .cin_o   (cin)
  );

  assign acc_sum = acc_q + addend + {{(PW-1){1'b0}}, cin};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_sh  <= '0;
      mplier_sh <= '0;
      acc_q     <= '0;
      prod_q    <= '0;
    end else if (accept) begin
      mcand_sh  <= {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
      mplier_sh <= {mplier_i, 1'b0};  // implied zero below the LSB
      acc_q     <= '0;
    end else if (busy) begin
      acc_q     <= acc_sum;
      mcand_sh  <= {mcand_sh[PW-3:0], 2'b00};
      mplier_sh <= {{2{mplier_sh[WIDTH]}}, mplier_sh[WIDTH:2]};
      if (last) prod_q <= acc_sum;
    end
  end

  assign busy_o    = busy;
  assign product_o = prod_q;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int unsigned PW    = 2 * WIDTH;
  localparam int unsigned STEPS = WIDTH / 2;
  localparam int unsigned CW    = $clog2(STEPS + 2);

  logic [CW-1:0] cyc_q;
  logic [PW-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      exp_q <= '0;
    end else if (start_i && !busy_o) begin
      cyc_q <= '0;
      exp_q <= $signed({{WIDTH{mcand_i[WIDTH-1]}}, mcand_i})
             * $signed({{WIDTH{mplier_i[WIDTH-1]}}, mplier_i});
    end else if (busy_o) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R3
  product_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == exp_q);
  // R4
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cyc_q == CW'(STEPS));
  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  busy_idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  busy_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R8
  product_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(product_o));
endmodule

bind radix4_booth_mul booth_mul_chk #(.WIDTH(WIDTH)) i_booth_mul_chk (.*);

// File: tb/test_radix4_booth_mul.sv
module test_radix4_booth_mul;
  localparam int unsigned WIDTH  = 8;
  localparam int unsigned PW     = 2 * WIDTH;
  localparam int unsigned STEPS  = WIDTH / 2;
  localparam time         CLK_PERIOD = 10ns;
  localparam int          NVEC   = 12;

  // {multiplicand, multiplier, product}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0D_FA_FFB2,  // 13 * -6 = -78
    32'h00_00_0000,
    32'h01_01_0001,
    32'hFF_FF_0001,
    32'h80_80_4000,  // R9
    32'h80_7F_C080,  // R9
    32'h7F_7F_3F01,
    32'h7F_80_C080,
    32'hFF_7F_FF81,  // R10
    32'h55_55_1C39,
    32'hAA_03_FEFE,  // R10
    32'h13_06_0072   // +2 and -2 digits
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [WIDTH-1:0]  mcand_i = '0;
  logic [WIDTH-1:0]  mplier_i = '0;
  logic              busy_o;
  logic              done_o;
  logic [PW-1:0]     product_o;

  int n_chk = 0;
  int n_bad = 0;

  radix4_booth_mul #(.WIDTH(WIDTH)) i_radix4_booth_mul (
    .clk_i, .rst_ni, .start_i, .mcand_i, .mplier_i, .busy_o, .done_o, .product_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge with busy low; returns at the done negedge.
  task automatic run_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic [PW-1:0] exp);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R5 R7 busy after accept", 32'(busy_o), 1);
    chk(done_o === 1'b0, "R4 no early done", 32'(done_o), 0);
    for (int k = 1; k < STEPS; k++) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R4 R5 done timing",
        {30'd0, done_o, busy_o}, 32'h2);
    chk(product_o === exp, "R3 R2 product", 32'(product_o), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic signed [PW-1:0] e;
    repeat (2) @(negedge clk_i);
    // R1
    chk(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1 in reset",
        {15'd0, busy_o, done_o, product_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1 after reset",
        {15'd0, busy_o, done_o, product_o}, 0);

    // R2 R3 R9 R10 table
    for (int i = 0; i < NVEC; i++)
      run_mul(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0]);

    // R3 R7 sweep, back to back
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        e = $signed(WIDTH'(a)) * $signed(WIDTH'(b));
        run_mul(WIDTH'(a), WIDTH'(b), e);
      end
    end

    // R6: start while busy is ignored
    @(negedge clk_i);
    start_i = 1'b1; mcand_i = 8'd7; mplier_i = 8'd9;
    @(negedge clk_i);
    mcand_i = 8'd100; mplier_i = 8'hC3;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 2; k < STEPS; k++) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_o === 1'b1, "R6 done of first op", 32'(done_o), 1);
    chk(product_o === 16'd63, "R6 product unaffected", 32'(product_o), 63);
    @(negedge clk_i);
    chk(busy_o === 1'b0, "R6 no second run", 32'(busy_o), 0);

    // R8: product held while idle
    repeat (3) @(negedge clk_i);
    chk(product_o === 16'd63 && done_o === 1'b0, "R8 hold",
        {15'd0, done_o, product_o}, 63);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule